// File: doc/BRIEF.md
# Three-Class DMA Bus Requester Arbiter

This block decides which DMA requester of a four-channel serial controller gets the next access to the shared system bus. There are nine requesters. One moves interrupt vectors. Four move receive data, one per channel. Four move transmit data, one per channel. The vector requester always comes first. Receive requests come next and transmit requests come last.

Inside the receive class and inside the transmit class, channels take turns in round-robin order. Each class has its own rotation pointer. When the priority-enable input is set, the channel named by the 2-bit preferred-channel input wins its class whenever it requests. The remaining channels keep rotating below it.

A grant is registered and then held until the bus-access-done pulse arrives. The bus protocol itself and the data movement are outside this block. The block sees each access only as a grant that lasts until that pulse.

Top module: `dma_grp_arbiter`

## Requirements
- R1: Synchronous active-low reset clears the grant, drives the group code to 0 and the channel field to 0, and sets both rotation pointers to channel 0. After reset, the first receive arbitration with all four receive requests active picks channel 0.
- R2: When no grant is outstanding and the vector request is active, the next grant goes to the vector requester, whatever the channel requests are.
- R3: When no grant is outstanding, the vector request is inactive and any receive request is active, the next grant goes to the receive class.
- R4: A transmit channel is granted only when neither the vector request nor any receive request is active at arbitration.
- R5: Within a class, the search starts at that class's pointer. When a non-promoted access ends, the pointer moves to the channel after the one served, wrapping from 3 to 0.
- R6: A class's pointer moves only when an access won by that class ends. Accesses by the other class or by the vector requester leave it unchanged.
- R7: With priority-enable at 1, a requesting channel whose number equals the preferred-channel field wins over the other channels of its class. It does not win over the vector requester or over a higher class.
- R8: When an access won by the preferred channel ends, its class pointer does not move.
- R9: A grant stays unchanged, whatever the requests do, until access-done is sampled high. The grant is then 0 on the next cycle.
- R10: When no grant is outstanding and at least one request is active on a rising edge, a grant is present right after that edge. While a grant is outstanding, no new arbitration takes place.
- R11: The grant is one-hot or zero. Bit 0 is the vector requester, bit 1+c is receive channel c, and bit 5+c is transmit channel c. The group code is 0 for none, 1 for vector, 2 for receive and 3 for transmit. The channel field gives the channel number, and is 0 for the vector requester.
- R12: An access-done pulse while no grant is outstanding has no effect: the grant stays 0 and neither pointer moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vec_req | input | 1 | Interrupt-vector transfer request |
| rx_req | input | 4 | Receive-channel data requests, bit c = channel c |
| tx_req | input | 4 | Transmit-channel data requests, bit c = channel c |
| access_done | input | 1 | Pulse marking the end of the current bus access |
| prio_en | input | 1 | Enables the preferred-channel promotion |
| prio_ch | input | 2 | Number of the preferred channel |
| grant | output | 9 | One-hot grant (see R11) |
| grant_grp | output | 2 | Class of the current grant |
| grant_ch | output | 2 | Channel of the current grant |

## Verification
The tests first raise every request at once, which shows whether the vector requester beats both channel classes. They then run all four receive requests in a row, and the order of winners shows where rotation starts after reset and how it wraps. A sparse transmit pattern (channels 1 and 3), followed by a return to the receive class, shows whether the two pointers are kept apart. With promotion enabled, runs where the preferred channel requests and runs where it does not show that promotion overrides rotation without moving the pointer. Last, requests that change while a grant is held, and a done pulse sent while idle, show the hold rule and that a stray pulse is ignored.

// File: rtl/dma_arb_pkg.sv
// Package: shared types for the grouped DMA requester arbiter.
// Assumes: group codes are visible at the top-level ports (R11).
package dma_arb_pkg;
    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_VEC  = 2'd1,
        GRP_RX   = 2'd2,
        GRP_TX   = 2'd3
    } grp_e;
endpackage

// File: rtl/dma_class_pick.sv
// Module: dma_class_pick
// Combinational picker for one channel class. It returns the promoted
// channel when promotion is on and that channel is requesting. Otherwise
// it returns the first requesting channel at or after the rotation pointer.
// Assumes: ptr and prio_ch hold channel numbers; out-of-range values of
// prio_ch never promote.
module dma_class_pick #(
    parameter int N_CH  = 4,
    parameter int CH_W  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0] req,
    input  logic [CH_W-1:0] ptr,
    input  logic            prio_en,
    input  logic [CH_W-1:0] prio_ch,
    output logic            hit,
    output logic [CH_W-1:0] idx,
    output logic            promoted
);
    logic prio_ok;

    // Promotion applies only to a valid, requesting preferred channel.
    always_comb begin
        prio_ok = prio_en && (int'(prio_ch) < N_CH) && req[prio_ch];
    end

    // Select the promoted channel, or else rotate from the pointer.
    always_comb begin
        int cand;
        hit      = 1'b0;
        idx      = '0;
        promoted = 1'b0;
        cand     = 0;
        if (prio_ok) begin
            hit      = 1'b1;
            idx      = prio_ch;
            promoted = 1'b1;
        end else begin
            for (int k = 0; k < N_CH; k++) begin
                cand = (int'(ptr) + k) % N_CH;
                if (!hit && req[cand]) begin
                    hit = 1'b1;
                    idx = CH_W'(cand);
                end
            end
        end
    end
endmodule

// File: rtl/dma_rr_ptr.sv
// Module: dma_rr_ptr
// Rotation pointer for one class. When an access won by this class ends,
// the pointer moves to the channel after the one served. It does not move
// if that access belonged to the promoted channel.
// Assumes: adv is a single-cycle strobe at the end of an access.
module dma_rr_ptr #(
    parameter int N_CH = 4,
    parameter int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            promoted,
    input  logic [CH_W-1:0] served,
    output logic [CH_W-1:0] ptr
);
    // Reset to channel 0; step past the served channel on a normal access end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv && !promoted) begin
            if (int'(served) == N_CH - 1) ptr <= '0;
            else                          ptr <= served + CH_W'(1);
        end
    end

    assert_ptr_promo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && promoted) |=> $stable(ptr));

    assert_ptr_other_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv) |=> $stable(ptr));

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !promoted) |=> (int'(ptr) == (int'($past(served)) + 1) % N_CH));
endmodule

// File: rtl/dma_grp_arbiter.sv
// Module: dma_grp_arbiter (top)
// Grants the shared bus to one DMA requester per access. The vector
// requester has the highest priority, then the receive class, then the
// transmit class. Each channel class uses dma_class_pick and keeps its
// own dma_rr_ptr. The grant is registered and held until access_done.
// Assumes: access_done is sampled only while a grant is outstanding.
module dma_grp_arbiter
    import dma_arb_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1,
    parameter int G_W  = 1 + 2 * N_CH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vec_req,
    input  logic [N_CH-1:0] rx_req,
    input  logic [N_CH-1:0] tx_req,
    input  logic            access_done,
    input  logic            prio_en,
    input  logic [CH_W-1:0] prio_ch,
    output logic [G_W-1:0]  grant,
    output logic [1:0]      grant_grp,
    output logic [CH_W-1:0] grant_ch
);
    localparam int N_CLS  = 2;   // class 0 = receive, class 1 = transmit
    localparam int RX_OFS = 1;
    localparam int TX_OFS = 1 + N_CH;

    logic [N_CH-1:0] cls_req  [N_CLS];
    logic [CH_W-1:0] cls_ptr  [N_CLS];
    logic [CH_W-1:0] cls_idx  [N_CLS];
    logic            cls_hit  [N_CLS];
    logic            cls_prom [N_CLS];
    logic            cls_adv  [N_CLS];

    logic [G_W-1:0]  gnt_q, gnt_d;
    grp_e            grp_q, grp_d;
    logic [CH_W-1:0] ch_q, ch_d;
    logic            prom_q, prom_d;
    logic            busy, any_req, issue, finish;

    // Route the request vectors to the class slices.
    always_comb begin
        cls_req[0] = rx_req;
        cls_req[1] = tx_req;
    end

    // Status terms for the grant register.
    always_comb begin
        busy    = |gnt_q;
        any_req = vec_req || (|rx_req) || (|tx_req);
        issue   = !busy && any_req;
        finish  = busy && access_done;
    end

    generate
        for (genvar c = 0; c < N_CLS; c++) begin : g_cls
            dma_class_pick #(.N_CH(N_CH), .CH_W(CH_W)) u_pick (
                .req      (cls_req[c]),
                .ptr      (cls_ptr[c]),
                .prio_en  (prio_en),
                .prio_ch  (prio_ch),
                .hit      (cls_hit[c]),
                .idx      (cls_idx[c]),
                .promoted (cls_prom[c])
            );

            // A class advances only at the end of an access it won.
            always_comb begin
                cls_adv[c] = finish && (grp_q == ((c == 0) ? GRP_RX : GRP_TX));
            end

            dma_rr_ptr #(.N_CH(N_CH), .CH_W(CH_W)) u_ptr (
                .clk      (clk),
                .rst_n    (rst_n),
                .adv      (cls_adv[c]),
                .promoted (prom_q),
                .served   (ch_q),
                .ptr      (cls_ptr[c])
            );
        end
    endgenerate

    // Fixed class order: vector, then receive, then transmit.
    always_comb begin
        gnt_d  = '0;
        grp_d  = GRP_NONE;
        ch_d   = '0;
        prom_d = 1'b0;
        if (vec_req) begin
            gnt_d[0] = 1'b1;
            grp_d    = GRP_VEC;
        end else if (cls_hit[0]) begin
            gnt_d[RX_OFS + int'(cls_idx[0])] = 1'b1;
            grp_d  = GRP_RX;
            ch_d   = cls_idx[0];
            prom_d = cls_prom[0];
        end else if (cls_hit[1]) begin
            gnt_d[TX_OFS + int'(cls_idx[1])] = 1'b1;
            grp_d  = GRP_TX;
            ch_d   = cls_idx[1];
            prom_d = cls_prom[1];
        end
    end

    // Grant register: clear on reset or end of access, load when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt_q  <= '0;
            grp_q  <= GRP_NONE;
            ch_q   <= '0;
            prom_q <= 1'b0;
        end else if (finish) begin
            gnt_q  <= '0;
            grp_q  <= GRP_NONE;
            ch_q   <= '0;
            prom_q <= 1'b0;
        end else if (issue) begin
            gnt_q  <= gnt_d;
            grp_q  <= grp_d;
            ch_q   <= ch_d;
            prom_q <= prom_d;
        end
    end

    assign grant     = gnt_q;
    assign grant_grp = grp_q;
    assign grant_ch  = ch_q;

    assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((|grant) == (grant_grp != GRP_NONE)));

    assert_vec_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && vec_req) |=> grant[0]);

    assert_rx_over_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !vec_req && (|rx_req)) |=> (grant_grp == GRP_RX));

    assert_tx_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (vec_req || (|rx_req))) |=> (grant_grp != GRP_TX));

    assert_prio_win_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !vec_req && prio_en && rx_req[prio_ch])
            |=> (grant_grp == GRP_RX) && (grant_ch == $past(prio_ch)));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !access_done) |=> $stable(grant));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && access_done) |=> (grant == '0));

    assert_issue_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && any_req) |=> (|grant));

    assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !any_req) |=> (grant == '0));
endmodule

// File: tb/sim_dma_grp_arbiter.sv
// Directed bench for dma_grp_arbiter: one task per scenario.
module sim_dma_grp_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vec_req = 1'b0;
    logic [3:0] rx_req = '0;
    logic [3:0] tx_req = '0;
    logic       access_done = 1'b0;
    logic       prio_en = 1'b0;
    logic [1:0] prio_ch = '0;
    logic [8:0] grant;
    logic [1:0] grant_grp;
    logic [1:0] grant_ch;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    dma_grp_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .vec_req(vec_req), .rx_req(rx_req),
        .tx_req(tx_req), .access_done(access_done), .prio_en(prio_en),
        .prio_ch(prio_ch), .grant(grant), .grant_grp(grant_grp),
        .grant_ch(grant_ch)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge with no grant: expect a grant one edge later,
    // then end the access and expect release.
    task automatic serve(input int grp, input int ch, input string tag);
        int exp_g;
        exp_g = (grp == 1) ? 1 : (grp == 2) ? (1 << (1 + ch)) : (1 << (5 + ch));
        chk({tag, " R10 idle before"}, int'(grant), 0);
        @(posedge clk); @(negedge clk);
        chk({tag, " R11 grant vector"}, int'(grant), exp_g);
        chk({tag, " R11 group"}, int'(grant_grp), grp);
        chk({tag, " R11 channel"}, int'(grant_ch), (grp == 1) ? 0 : ch);
        access_done = 1'b1;
        @(negedge clk);
        access_done = 1'b0;
        chk({tag, " R9 released"}, int'(grant), 0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset grant", int'(grant), 0);
        chk("R1 reset group", int'(grant_grp), 0);
        chk("R1 reset channel", int'(grant_ch), 0);
    endtask

    task automatic t_classes;
        vec_req = 1'b1; rx_req = 4'hF; tx_req = 4'hF;
        serve(1, 0, "R2 vector over all");
        vec_req = 1'b0;
        serve(2, 0, "R1 R3 first rx after reset");
        serve(2, 1, "R5 rx rotate 1");
        serve(2, 2, "R5 rx rotate 2");
        serve(2, 3, "R5 rx rotate 3");
        serve(2, 0, "R5 rx wrap");
    endtask

    task automatic t_tx_split;
        rx_req = 4'h0; tx_req = 4'b1010;
        serve(3, 1, "R4 tx sparse a");
        serve(3, 3, "R4 tx sparse b");
        serve(3, 1, "R4 tx sparse wrap");
        rx_req = 4'hF; tx_req = 4'hF;
        serve(2, 1, "R6 rx pointer untouched by tx");
    endtask

    task automatic t_promote;
        prio_en = 1'b1; prio_ch = 2'd3; rx_req = 4'hF; tx_req = 4'h0;
        serve(2, 3, "R7 promoted rx");
        serve(2, 3, "R7 promoted rx again");
        rx_req = 4'b0111;
        serve(2, 2, "R8 pointer kept after promoted");
        serve(2, 0, "R5 R7 rotate below promoted");
        rx_req = 4'h0; tx_req = 4'hF;
        serve(3, 3, "R7 promoted tx");
        vec_req = 1'b1; rx_req = 4'b1000;
        serve(1, 0, "R7 vector beats promoted");
        vec_req = 1'b0; rx_req = 4'h0; tx_req = 4'h0; prio_en = 1'b0;
    endtask

    task automatic t_hold;
        rx_req = 4'b0001;
        chk("R10 idle before hold", int'(grant), 0);
        @(posedge clk); @(negedge clk);
        chk("R9 hold initial grant", int'(grant), 2);
        vec_req = 1'b1; tx_req = 4'hF; rx_req = 4'hE;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 grant held", int'(grant), 2);
        end
        access_done = 1'b1;
        @(negedge clk);
        access_done = 1'b0;
        chk("R9 released after hold", int'(grant), 0);
        serve(1, 0, "R2 vector after hold");
        vec_req = 1'b0; rx_req = 4'h0; tx_req = 4'h0;
    endtask

    task automatic t_stray_done;
        @(negedge clk);
        access_done = 1'b1;
        @(negedge clk);
        access_done = 1'b0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R12 no grant after stray done", int'(grant), 0);
        end
        rx_req = 4'hF;
        serve(2, 1, "R12 pointer unmoved by stray done");
        rx_req = 4'h0;
    endtask

    initial begin
        t_reset();
        t_classes();
        t_tx_split();
        t_promote();
        t_hold();
        t_stray_done();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule